// File: doc/BRIEF.md
# Synchronized Multiplexed Address/Data Bus Slave

This block is a slave port behind an asynchronous 32-bit bus on which an external processor sends an address and then data over the same lines. The bus has an active-low chip select, an active-low write enable, an active-low read enable and an active-high address-latch strobe. Every strobe and every one of the 32 shared lines passes through a two-flop synchronizer before any logic sees it, and no logic reads the first synchronizer flop.

The address phase is found by forming "chip select active and address latch active" combinationally from the synchronized signals and registering that condition for one cycle. The address is captured on the single cycle where the live condition is true and its registered copy is false. This reacts one cycle sooner than an edge detector built on an extra flop, so the synchronized bus still holds the address when it is captured. Writes use the same scheme on chip select and write enable. Reads drive the addressed register onto separate output lines and raise an output enable for the external pad buffer. Behind the port sits a file of sixteen 32-bit registers.

Top module: `muxbus_slave`

## Requirements
- R1: While `rst_n` is low, every register, the latched address and all detection flags clear. After reset `bus_ad_oe` is 0, `bus_ad_out` is 0, and every register reads 0.
- R2: When `bus_cs_n` is 0 and `bus_ale` is 1, the bus value is captured as the address on the third rising edge after the pins change. This accounts for two synchronizer stages and one capture register. Capture happens once per assertion.
- R3: An address-latch pulse that stays high across only two rising clock edges is still captured.
- R4: When `bus_cs_n` and `bus_we_n` are both 0 and `bus_ale` is 0, the bus value is written to the register selected by bits [5:2] of the latched address.
- R5: When `bus_cs_n` and `bus_oe_n` are both 0 and `bus_ale` is 0, `bus_ad_oe` is 1 and `bus_ad_out` carries the selected register. Both appear after the second rising edge following the pin change.
- R6: One write-enable assertion writes exactly once, using the data present when it is first seen. Later changes on the bus during the same assertion have no effect.
- R7: An address with any of bits [31:6] set is out of range. A write to it changes no register, and a read from it returns 0 with `bus_ad_oe` at 1.
- R8: When no read is in progress, `bus_ad_oe` is 0 and `bus_ad_out` is 0. This includes `bus_oe_n` at 0 while `bus_cs_n` is 1.
- R9: An address-latch pulse while `bus_cs_n` is 1 leaves the latched address unchanged.
- R10: Address bits [1:0] do not take part in register selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_we_n | input | 1 | Write enable, active low, asynchronous |
| bus_oe_n | input | 1 | Read enable, active low, asynchronous |
| bus_ale | input | 1 | Address latch, active high: lines carry an address |
| bus_ad_in | input | 32 | Shared address/data lines, from the pad |
| bus_ad_out | output | 32 | Read data to the pad |
| bus_ad_oe | output | 1 | Pad output enable, active high |

## Verification
A wrong latched address shows up as read data from the wrong register on the next read phase, which is two cycles after the read enable is seen. A detection flag stuck high stops a later address or write from taking effect. A flag stuck low turns one write into repeated writes, so data from late in the strobe overwrites the first value. Both effects are visible on the first read-back. A fault in the register file or the range check appears as a wrong or non-zero value on `bus_ad_out` in the same read.

// File: rtl/muxbus_pkg.sv
// Shared widths and helpers for the multiplexed bus slave.
// Assumes a byte-addressed bus whose registers are one bus word wide.
package muxbus_pkg;
    localparam int unsigned BUS_W    = 32;  // shared address/data lines
    localparam int unsigned NUM_REGS = 16;  // register file depth
    localparam int unsigned BYTE_LSB = 2;   // address bits below a word
    localparam int unsigned CTRL_W   = 4;   // {ale, oe_n, we_n, cs_n}

    // Control bit positions inside the synchronized control vector
    localparam int unsigned C_CS  = 0;
    localparam int unsigned C_WE  = 1;
    localparam int unsigned C_OE  = 2;
    localparam int unsigned C_ALE = 3;

    // Idle level of the control pins: strobes deasserted
    localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b0111;
endpackage

// File: rtl/muxbus_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is sampled on its own; for a multi-bit value, the
// driver keeps it stable for at least one clock around its use.
// Only the second stage leaves this module.
module muxbus_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;

    // Two-stage capture; stage1 may be metastable and stays local
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/muxbus_detect.sv
// Phase detector: one-cycle pulse when a live condition turns true.
// It compares the condition with its own one-cycle-old copy, so it
// reacts in the same cycle the synchronized inputs show the phase.
// Assumes the condition comes from already synchronized signals.
module muxbus_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic pulse
);
    logic cond_q;

    // Remember the condition from the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end

    // Pulse on the first cycle of the condition
    always_comb pulse = cond & ~cond_q;
endmodule

// File: rtl/muxbus_regfile.sv
// Register file behind the bus port, indexed by word address.
// Words whose upper address bits are non-zero are out of range:
// they read as zero and are not written.
module muxbus_regfile #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned WADR_W = 30,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WADR_W-1:0] word_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [IDX_W-1:0]  idx;
    logic              in_range;
    logic [DATA_W-1:0] regs [DEPTH];

    // Split the word address into index and range check
    always_comb begin
        idx      = word_addr[IDX_W-1:0];
        in_range = (word_addr[WADR_W-1:IDX_W] == '0);
    end

    // One storage word per register, each with its own write decode
    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && in_range && (idx == IDX_W'(g)))
                regs[g] <= wdata;
        end
    end

    // Read mux, forced to zero out of range
    always_comb rdata = in_range ? regs[idx] : '0;
endmodule

// File: rtl/muxbus_slave.sv
// Slave port for an asynchronous multiplexed address/data bus.
// All pins pass through two-flop synchronizers; the address phase
// and write phase are found on the synchronized signals, and reads
// drive the addressed register onto separate out/enable pad lines.
// Assumes the bus lines are stable one clock before and after the
// latch strobe and the address-latch pulse spans two clock edges.
module muxbus_slave
    import muxbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_cs_n,
    input  logic             bus_we_n,
    input  logic             bus_oe_n,
    input  logic             bus_ale,
    input  logic [BUS_W-1:0] bus_ad_in,
    output logic [BUS_W-1:0] bus_ad_out,
    output logic             bus_ad_oe
);
    localparam int unsigned WADR_W = BUS_W - BYTE_LSB;

    logic [CTRL_W-1:0] ctrl_s;
    logic [BUS_W-1:0]  ad_s;
    logic              addr_cond, wr_cond, rd_cond;
    logic              addr_stb, wr_stb;
    logic [WADR_W-1:0] addr_q;
    logic [BUS_W-1:0]  rd_data;

    muxbus_sync #(.W(CTRL_W), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({bus_ale, bus_oe_n, bus_we_n, bus_cs_n}),
        .q_sync  (ctrl_s)
    );

    muxbus_sync #(.W(BUS_W), .RST_VAL('0)) u_sync_ad (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (bus_ad_in),
        .q_sync  (ad_s)
    );

    // Live phase conditions from the synchronized pins
    always_comb begin
        addr_cond = ~ctrl_s[C_CS] & ctrl_s[C_ALE];
        wr_cond   = ~ctrl_s[C_CS] & ~ctrl_s[C_WE] & ~ctrl_s[C_ALE];
        rd_cond   = ~ctrl_s[C_CS] & ~ctrl_s[C_OE] & ~ctrl_s[C_ALE];
    end

    muxbus_detect u_det_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (addr_cond),
        .pulse (addr_stb)
    );

    muxbus_detect u_det_wr (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (wr_cond),
        .pulse (wr_stb)
    );

    // Latch the word address on the first address-phase cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_q <= '0;
        else if (addr_stb) addr_q <= ad_s[BUS_W-1:BYTE_LSB];
    end

    muxbus_regfile #(
        .DATA_W (BUS_W),
        .DEPTH  (NUM_REGS),
        .WADR_W (WADR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_stb),
        .word_addr (addr_q),
        .wdata     (ad_s),
        .rdata     (rd_data)
    );

    // Drive the pad only during a read phase; lines are zero otherwise
    always_comb begin
        bus_ad_oe  = rd_cond;
        bus_ad_out = rd_cond ? rd_data : '0;
    end
endmodule

// File: rtl/muxbus_slave_chk.sv
// Assertion checker for the bus slave, bound to every instance.
module muxbus_slave_chk #(
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned WADR_W = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_cs_n,
    input logic             bus_oe_n,
    input logic             bus_ale,
    input logic [BUS_W-1:0] bus_ad_out,
    input logic             bus_ad_oe,
    input logic             addr_stb,
    input logic             wr_stb,
    input logic [WADR_W-1:0] addr_q
);
    AST_ADDR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |=> !addr_stb);                                          // R2
    AST_ADDR_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_q) |-> $past(addr_stb));                            // R2
    AST_WR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);                                              // R6
    AST_OE_FROM_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ad_oe |-> ($past(!bus_cs_n, 2) && $past(!bus_oe_n, 2) && $past(!bus_ale, 2))); // R5
    AST_IDLE_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ad_oe |-> (bus_ad_out == '0));                               // R8
    AST_ADDR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        addr_stb |-> ($past(!bus_cs_n, 2) && $past(bus_ale, 2)));         // R9
endmodule

bind muxbus_slave muxbus_slave_chk #(
    .BUS_W  (muxbus_pkg::BUS_W),
    .WADR_W (muxbus_pkg::BUS_W - muxbus_pkg::BYTE_LSB)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_cs_n   (bus_cs_n),
    .bus_oe_n   (bus_oe_n),
    .bus_ale    (bus_ale),
    .bus_ad_out (bus_ad_out),
    .bus_ad_oe  (bus_ad_oe),
    .addr_stb   (addr_stb),
    .wr_stb     (wr_stb),
    .addr_q     (addr_q)
);

// File: tb/muxbus_slave_tb.sv
module muxbus_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1, bus_ale = 1'b0;
    logic [31:0] bus_ad_in = '0;
    logic [31:0] bus_ad_out;
    logic        bus_ad_oe;
    int          n_checks = 0, n_fails = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    muxbus_slave u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
        .bus_oe_n(bus_oe_n), .bus_ale(bus_ale), .bus_ad_in(bus_ad_in),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe)
    );

    // Vector: {is_read, address, data}; reads expect data
    localparam logic [64:0] VEC [8] = '{
        {1'b0, 32'h0000_0000, 32'hA5A5_0001},
        {1'b0, 32'h0000_0004, 32'h1234_5678},
        {1'b0, 32'h0000_003C, 32'hDEAD_BEEF},
        {1'b0, 32'h0000_0020, 32'h0000_FFFF},
        {1'b1, 32'h0000_0004, 32'h1234_5678},
        {1'b1, 32'h0000_003C, 32'hDEAD_BEEF},
        {1'b1, 32'h0000_0000, 32'hA5A5_0001},
        {1'b1, 32'h0000_0020, 32'h0000_FFFF}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        bus_cs_n = 1'b1; bus_we_n = 1'b1; bus_oe_n = 1'b1; bus_ale = 1'b0;
    endtask

    // Address phase with the latch held for ale_edges rising edges
    task automatic addr_phase(input logic [31:0] a, input int ale_edges, input bit cs_on);
        @(negedge clk);
        bus_ad_in = a; bus_cs_n = !cs_on; bus_ale = 1'b1;
        repeat (ale_edges) @(negedge clk);
        bus_ale = 1'b0;
        repeat (3) @(negedge clk);
        idle_bus();
        repeat (2) @(negedge clk);
    endtask

    // Write phase; if late_data differs, bus changes mid-strobe
    task automatic write_phase(input logic [31:0] d, input logic [31:0] late_data);
        @(negedge clk);
        bus_ad_in = d; bus_cs_n = 1'b0; bus_we_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_ad_in = late_data;
        repeat (4) @(negedge clk);
        idle_bus();
        repeat (3) @(negedge clk);
    endtask

    // Read phase, sampled four edges in; then checks idle release
    task automatic read_phase(input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_ad_in = '0; bus_cs_n = 1'b0; bus_oe_n = 1'b0;
        repeat (4) @(negedge clk);
        check(bus_ad_oe === 1'b1, req, {31'b0, bus_ad_oe}, 32'h1);
        check(bus_ad_out === exp, req, bus_ad_out, exp);
        idle_bus();
        repeat (3) @(negedge clk);
        check(bus_ad_oe === 1'b0 && bus_ad_out === '0, "R8", bus_ad_out, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check(bus_ad_oe === 1'b0 && bus_ad_out === '0, "R1", bus_ad_out, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        addr_phase(32'h0000_000C, 4, 1'b1);
        read_phase(32'h0, "R1");

        // R4/R5: vector table
        foreach (VEC[i]) begin
            addr_phase(VEC[i][63:32], 4, 1'b1);
            if (VEC[i][64]) read_phase(VEC[i][31:0], "R5");
            else            write_phase(VEC[i][31:0], VEC[i][31:0]);
        end

        // R3: short latch pulses for both write and read
        addr_phase(32'h0000_0010, 2, 1'b1);
        write_phase(32'hCAFE_0004, 32'hCAFE_0004);
        addr_phase(32'h0000_0010, 2, 1'b1);
        read_phase(32'hCAFE_0004, "R3");
        addr_phase(32'h0000_0020, 4, 1'b1);
        read_phase(32'h0000_FFFF, "R3");

        // R10: low byte bits ignored
        addr_phase(32'h0000_0007, 4, 1'b1);
        write_phase(32'h1111_2222, 32'h1111_2222);
        addr_phase(32'h0000_0004, 4, 1'b1);
        read_phase(32'h1111_2222, "R10");

        // R6: data change during one write strobe is not written
        addr_phase(32'h0000_0008, 4, 1'b1);
        write_phase(32'h0BAD_0001, 32'h7777_9999);
        addr_phase(32'h0000_0008, 4, 1'b1);
        read_phase(32'h0BAD_0001, "R6");

        // R7: out-of-range write ignored, read gives zero
        addr_phase(32'h0000_0040, 4, 1'b1);
        write_phase(32'hFFFF_0000, 32'hFFFF_0000);
        read_phase(32'h0, "R7");
        addr_phase(32'h0000_0000, 4, 1'b1);
        read_phase(32'hA5A5_0001, "R7");

        // R9: latch pulse with chip select high keeps the old address
        addr_phase(32'h0000_003C, 4, 1'b1);
        addr_phase(32'h0000_0000, 4, 1'b0);
        read_phase(32'hDEAD_BEEF, "R9");

        // R2: captured address is taken from the bus during the latch
        addr_phase(32'h0000_0024, 4, 1'b1);
        read_phase(32'h0, "R2");

        // R8: read enable without chip select does not drive
        @(negedge clk);
        bus_oe_n = 1'b0;
        repeat (4) @(negedge clk);
        check(bus_ad_oe === 1'b0 && bus_ad_out === '0, "R8", bus_ad_out, 32'h0);
        idle_bus();

        // R1: reset mid-run clears the register file
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(bus_ad_oe === 1'b0, "R1", {31'b0, bus_ad_oe}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        addr_phase(32'h0000_003C, 4, 1'b1);
        read_phase(32'h0, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule